// File: doc/BRIEF.md
# Remote DMA Transfer Engine

This engine moves a block of data between local buffer memory and a host port. The host first writes a 16-bit start address and a 16-bit byte length into four 8-bit configuration registers. It then pulses `start`, choosing the direction and whether each memory access carries one byte or one 16-bit word. While the transfer runs, the engine issues one memory access per step.

After each accepted access, the engine moves its live address forward by the access size and takes the same amount off the remaining length. The live address can be observed at any time on `cur_addr`. It is kept apart from the programmed start address, so the host may set up the next block while a transfer is still running. The transfer ends when the remaining length falls below one access size. That happens when the length reaches zero, or when it is left at one in word mode. The engine then pulses `done` and returns to idle.

On a read transfer, each word taken from memory appears on `host_rdata` with a one-cycle `host_rvalid` strobe. On a write transfer, the memory write data is taken from `host_wdata`.

Top module: `rdma_engine`

## Requirements
- R1: After reset, `busy`, `done`, `cur_addr`, `remain`, `mem_req` and `host_rvalid` are all zero.
- R2: A `cfg_we` write with `cfg_sel` = 0 sets start-address bits 7:0, 1 sets bits 15:8, 2 sets length bits 7:0 and 3 sets length bits 15:8. A `start` pulse seen while idle loads `cur_addr` with the start address and `remain` with the length on the next clock edge.
- R3: In byte mode (`word_mode` = 0), each access accepted by `mem_ready` adds 1 to `cur_addr` and subtracts 1 from `remain`. A length of N gives exactly N accesses.
- R4: In word mode (`word_mode` = 1), `mem_word` is high during accesses. Each accepted access adds 2 to `cur_addr` and subtracts 2 from `remain`.
- R5: While `mem_req` is high, `mem_addr` and `cur_addr` both equal the start address plus the bytes already moved.
- R6: `done` is high for exactly one cycle, in the cycle after the final accepted access. `busy` is low in that same cycle.
- R7: While `mem_req` is high and `mem_ready` is low, `cur_addr` and `remain` hold their values.
- R8: A word-mode transfer with an odd length L makes (L-1)/2 accesses. It finishes with `remain` = 1.
- R9: A start with length 0, or with length 1 in word mode, raises `done` in the cycle after `start`. No memory access is made in that case.
- R10: A `start` pulse or a configuration write during a transfer does not change the address sequence or the access count of that transfer.
- R11: On a read transfer (`dir_wr` = 0), `host_rdata` shows the `mem_rdata` of each accepted access one cycle later, with a one-cycle `host_rvalid`. On a write transfer, `mem_we` is high and `mem_wdata` equals `host_wdata`.
- R12: The live address wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0/1 address low/high, 2/3 length low/high |
| cfg_wdata | input | 8 | Configuration write byte |
| start | input | 1 | Begin a transfer (ignored while busy) |
| dir_wr | input | 1 | 1 = host to memory, 0 = memory to host |
| word_mode | input | 1 | 1 = 16-bit accesses, 0 = byte accesses |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_addr | output | 16 | Live transfer address |
| remain | output | 16 | Bytes still to move |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_word | output | 1 | Access is a 16-bit word |
| mem_addr | output | 16 | Memory access address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 16 | Memory read data |
| host_wdata | input | 16 | Host data for write transfers |
| host_rdata | output | 16 | Read data delivered to the host |
| host_rvalid | output | 1 | `host_rdata` valid strobe |

## Verification
Byte reads with `mem_ready` held high set the one-byte step and the exact access count against the word step. A word write with periodic `mem_ready` stalls separates a correct hold from an engine that advances without a grant. An odd word length, a zero length and a length of one in word mode expose mistakes in the completion rule. Two further runs cover the rest. A byte read starting at 0xFFFE checks address wrap. A run that fires `start` and a configuration write in mid-transfer shows whether the live address is kept apart from the programmed registers.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned ADDR_W = BYTE_W * LANES;
    localparam int unsigned CNT_W  = ADDR_W;
    localparam int unsigned DATA_W = 2 * BYTE_W;
    localparam int unsigned SEL_W  = 1 + $clog2(LANES);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  busy;
        logic  dir_wr;
        logic  word;
        addr_t addr;
        cnt_t  remain;
        logic  done;
        data_t rdata;
        logic  rvalid;
    } eng_state_t;
endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
    import rdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [BYTE_W-1:0] wdata,
    output addr_t            start_addr,
    output cnt_t             length
);
    localparam int unsigned LANE_W = SEL_W - 1;

    logic              is_len;
    logic [LANE_W-1:0] lane;

    assign is_len = sel[SEL_W-1];
    assign lane   = sel[LANE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] addr_d, addr_q;
        logic [BYTE_W-1:0] len_d, len_q;
        logic              hit;

        assign hit = we && (lane == LANE_W'(g));

        always_comb begin
            addr_d = addr_q;
            len_d  = len_q;
            if (hit) begin
                if (is_len) begin
                    len_d = wdata;
                end else begin
                    addr_d = wdata;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                len_q  <= '0;
            end else begin
                addr_q <= addr_d;
                len_q  <= len_d;
            end
        end

        assign start_addr[g*BYTE_W +: BYTE_W] = addr_q;
        assign length[g*BYTE_W +: BYTE_W]     = len_q;
    end
endmodule

// File: rtl/rdma_step.sv
module rdma_step
    import rdma_pkg::*;
(
    input  cnt_t remain,
    input  logic word,
    output cnt_t step,
    output cnt_t next_remain,
    output logic now_term,
    output logic next_term
);
    always_comb begin
        step        = word ? CNT_W'(2) : CNT_W'(1);
        now_term    = remain < step;
        next_remain = remain - step;
        next_term   = next_remain < step;
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              dir_wr,
    input  logic              word_mode,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remain,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);
    eng_state_t st_d, st_q;

    addr_t start_addr;
    cnt_t  length;

    cnt_t  step_remain;
    logic  step_word;
    cnt_t  step;
    cnt_t  next_remain;
    logic  now_term;
    logic  next_term;

    rdma_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .start_addr (start_addr),
        .length     (length)
    );

    // One stepper serves both the launch check (idle) and the running step.
    assign step_remain = st_q.busy ? st_q.remain : length;
    assign step_word   = st_q.busy ? st_q.word   : word_mode;

    rdma_step u_step (
        .remain      (step_remain),
        .word        (step_word),
        .step        (step),
        .next_remain (next_remain),
        .now_term    (now_term),
        .next_term   (next_term)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.rvalid = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.addr   = start_addr;
                st_d.remain = length;
                st_d.word   = word_mode;
                st_d.dir_wr = dir_wr;
                if (now_term) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else if (mem_ready) begin
            st_d.addr   = st_q.addr + ADDR_W'(step);
            st_d.remain = next_remain;
            if (!st_q.dir_wr) begin
                st_d.rdata  = mem_rdata;
                st_d.rvalid = 1'b1;
            end
            if (next_term) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign done        = st_q.done;
    assign cur_addr    = st_q.addr;
    assign remain      = st_q.remain;
    assign mem_req     = st_q.busy;
    assign mem_we      = st_q.busy & st_q.dir_wr;
    assign mem_word    = st_q.busy & st_q.word;
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = host_wdata;
    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk
    import rdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  remain,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_word,
    input logic              mem_ready,
    input logic              host_rvalid
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> ($stable(cur_addr) && $stable(remain))); // R7

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_word) |=>
        (cur_addr == $past(cur_addr) + ADDR_W'(1) && remain == $past(remain) - CNT_W'(1))); // R3

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_word) |=>
        (cur_addr == $past(cur_addr) + ADDR_W'(2) && remain == $past(remain) - CNT_W'(2))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

    AST_BUSY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain >= (mem_word ? CNT_W'(2) : CNT_W'(1)))); // R8

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(mem_req && mem_ready && !mem_we)); // R11
endmodule

bind rdma_engine rdma_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .cur_addr    (cur_addr),
    .remain      (remain),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_word    (mem_word),
    .mem_ready   (mem_ready),
    .host_rvalid (host_rvalid)
);

// File: tb/rdma_engine_tb.sv
module rdma_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        start = 1'b0;
    logic        dir_wr = 1'b0;
    logic        word_mode = 1'b0;
    logic        busy, done, mem_req, mem_we, mem_word, host_rvalid;
    logic [15:0] cur_addr, remain, mem_addr, mem_wdata, host_rdata;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_rdata, host_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata  = mem_addr ^ 16'hC3A5;
    assign host_wdata = mem_addr + 16'h0101;

    rdma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .dir_wr(dir_wr), .word_mode(word_mode), .busy(busy), .done(done),
        .cur_addr(cur_addr), .remain(remain), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 cur_addr", {16'd0, cur_addr}, 0);
        chk("R1 remain", {16'd0, remain}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 host_rvalid", {31'd0, host_rvalid}, 0);
    endtask

    // One transfer: program, start, follow every access, check completion.
    task automatic run(input string req, input bit wr, input bit word, input logic [15:0] saddr,
                       input logic [15:0] cnt, input int stall_mod, input bit disturb);
        int step = word ? 2 : 1;
        int exp_acc = word ? cnt / 2 : cnt;
        int n = 0;
        int cyc = 0;
        bit prev_read = 0;
        bit prev_acc = 0;
        logic [15:0] prev_addr = '0;
        cfg_write(2'd0, saddr[7:0]);
        cfg_write(2'd1, saddr[15:8]);
        cfg_write(2'd2, cnt[7:0]);
        cfg_write(2'd3, cnt[15:8]);
        @(negedge clk);
        start = 1'b1; dir_wr = wr; word_mode = word;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk({req, " R2 loaded addr"}, {16'd0, cur_addr}, {16'd0, saddr});
        chk({req, " R2 loaded len"}, {16'd0, remain}, {16'd0, cnt});
        while (cyc < 5000) begin
            if (prev_read) begin
                chk({req, " R11 rvalid"}, {31'd0, host_rvalid}, 1);
                chk({req, " R11 rdata"}, {16'd0, host_rdata}, {16'd0, prev_addr ^ 16'hC3A5});
            end else begin
                chk({req, " R11 no rvalid"}, {31'd0, host_rvalid}, 0);
            end
            if (done) break;
            mem_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
            if (disturb && cyc == 1) begin
                start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'hEE;
            end else begin
                start = 1'b0; cfg_we = 1'b0;
            end
            #1;
            prev_read = 0;
            prev_acc = 0;
            if (mem_req && mem_ready) begin
                chk({req, " R5 mem_addr"}, {16'd0, mem_addr}, 32'(16'(saddr + 16'(n * step))));
                chk({req, " R5 cur_addr"}, {16'd0, cur_addr}, {16'd0, mem_addr});
                chk({req, " R4 mem_word"}, {31'd0, mem_word}, {31'd0, word});
                if (wr) begin
                    chk({req, " R11 mem_we"}, {31'd0, mem_we}, 1);
                    chk({req, " R11 mem_wdata"}, {16'd0, mem_wdata}, {16'd0, mem_addr + 16'h0101});
                end
                prev_read = !wr;
                prev_acc = 1;
                prev_addr = mem_addr;
                n++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; cfg_we = 1'b0; mem_ready = 1'b1;
        chk({req, " R6 done seen"}, {31'd0, done}, 1);
        chk({req, " R6 busy low at done"}, {31'd0, busy}, 0);
        if (exp_acc == 0) begin
            chk({req, " R9 done one cycle after start"}, 32'(cyc), 0);
        end else begin
            chk({req, " R6 done after last access"}, {31'd0, prev_acc}, 1);
        end
        chk({req, " access count"}, 32'(n), 32'(exp_acc));
        chk({req, " final addr"}, {16'd0, cur_addr}, 32'(16'(saddr + 16'(exp_acc * step))));
        chk({req, " final remain"}, {16'd0, remain}, 32'(16'(cnt - 16'(exp_acc * step))));
        @(negedge clk);
        chk({req, " R6 done one cycle"}, {31'd0, done}, 0);
        chk({req, " R6 idle after"}, {31'd0, mem_req}, 0);
    endtask

    initial begin
        t_reset();
        run("R3 byte read", 1'b0, 1'b0, 16'h1234, 16'd5, 0, 1'b0);
        run("R4 R7 word write stalled", 1'b1, 1'b1, 16'h2000, 16'd8, 3, 1'b0);
        run("R8 odd word read", 1'b0, 1'b1, 16'h3001, 16'd7, 2, 1'b0);
        run("R9 zero length", 1'b1, 1'b0, 16'h4444, 16'd0, 0, 1'b0);
        run("R9 word length one", 1'b0, 1'b1, 16'h5555, 16'd1, 0, 1'b0);
        run("R12 wrap", 1'b0, 1'b0, 16'hFFFE, 16'd4, 0, 1'b0);
        run("R10 disturbed", 1'b0, 1'b0, 16'h0100, 16'd6, 0, 1'b1);
        run("R3 byte write stalled", 1'b1, 1'b0, 16'h0A0F, 16'd3, 2, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule